// File: doc/BRIEF.md
# Two-Way Lockable Data Cache

This block is a data cache controller placed between the load/store port of a pipelined core and an external memory. It is two-way set associative and keeps a tag, a valid bit, a dirty bit and a lock bit for every line, plus one least-recently-used bit per set. Every request carries a physical word address, so no translation happens here. Every request also carries a write-policy attribute that picks write-back or write-through for that access alone. The tag compare runs one cycle after the arrays are read, against the registered request address.

On a miss the controller picks a victim among the unlocked ways. If the victim is dirty, its whole line is copied into a small write buffer. The controller then refills the line one word at a time. The refill starts at the requested word and wraps around the line, and the core gets its answer as soon as that first word is in the array. When both ways of a set are locked, the access bypasses the cache and nothing is allocated. Memory reads wait until the write buffer has drained, so a read never returns data older than a posted write.

Top module: `dc_cache`

## Requirements
- R1: After reset, req_ready is high, resp_valid, mem_rd_req and mem_wr_valid are low, and every line is invalid and unlocked, so the first access to any set misses.
- R2: A load that hits asserts resp_valid with the word in the first cycle after the clock edge that accepted it, and issues no memory read.
- R3: A load miss refills the line with four single-word memory reads. The first read is the requested word (word offset = address bits [1:0]) and the rest follow in ascending order, modulo 4.
- R4: The response to a miss is given in the cycle the first (requested) word arrives, while the other three words are still outstanding.
- R5: An access with req_lock=1 sets the lock bit of the line it hits or allocates. A locked line is never chosen as a replacement victim.
- R6: An invalid way is filled before any valid one, way 0 first. Otherwise the LRU bit picks the victim among unlocked ways. The LRU bit is updated on every hit and every fill.
- R7: With both ways of the set locked, a load is served by one single-word memory read, a store is posted straight to the write buffer, and no line is allocated.
- R8: A write-back store that hits updates the line and marks it dirty, and produces no memory write.
- R9: A dirty victim sends all four of its words to memory through the write buffer before the refill. A clean victim produces no memory write.
- R10: A write-through store (req_wthru=1) that hits updates the line and posts exactly one memory write.
- R11: A write-through store that misses posts one memory write and allocates no line.
- R12: A write-back store that misses allocates the line through a refill, and the store data replaces the requested word.
- R13: Memory reads start only after the write buffer is empty, so every load returns the most recently stored value for its address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Controller idle; request accepted on this edge |
| req_write | input | 1 | 1 = store, 0 = load |
| req_wthru | input | 1 | 1 = write-through, 0 = write-back for this access |
| req_lock | input | 1 | Lock the line this access hits or allocates |
| req_addr | input | 30 | Physical word address |
| req_wdata | input | 32 | Store data |
| resp_valid | output | 1 | Response pulse (load data or store acknowledge) |
| resp_rdata | output | 32 | Load data |
| mem_rd_req | output | 1 | Single-word read request pulse |
| mem_rd_addr | output | 30 | Read word address |
| mem_rd_valid | input | 1 | Read data returned |
| mem_rd_data | input | 32 | Read data |
| mem_wr_valid | output | 1 | Write buffer head valid |
| mem_wr_ready | input | 1 | Memory takes the head write |
| mem_wr_addr | output | 30 | Write word address |
| mem_wr_data | output | 32 | Write data |

## Verification
A load hit is due in the first cycle after the accepting edge. The bench drives requests on the falling edge and samples resp_valid exactly one falling edge later. A miss answers in the cycle its first read word returns. The bench counts the memory read pulses seen up to that response and expects exactly one, then expects four once the controller is idle again. It also checks the wrap order of the read addresses. Memory-side effects of stores and evictions only appear once the write buffer drains, so those are checked after the bench has waited for an idle controller and an empty write port.

// File: rtl/dc_pkg.sv
package dc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CMP   = 3'd1,
    ST_EVICT = 3'd2,
    ST_FILL  = 3'd3,
    ST_UNC   = 3'd4
  } dc_state_e;
endpackage

// File: rtl/dc_rst_sync.sv
module dc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_s = sync_q[1];
endmodule

// File: rtl/dc_victim.sv
module dc_victim (
  input  logic [1:0] vld,
  input  logic [1:0] lck,
  input  logic       lru,
  output logic       way,
  output logic       none
);
  always_comb begin
    none = &lck;
    if (lck[0])       way = 1'b1;
    else if (lck[1])  way = 1'b0;
    else if (!vld[0]) way = 1'b0;
    else if (!vld[1]) way = 1'b1;
    else              way = lru;
  end
endmodule

// File: rtl/dc_wbuf.sv
module dc_wbuf #(
  parameter int DEPTH = 4,
  parameter int AW    = 30,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_s,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_data,
  output logic          full,
  output logic          empty,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] out_addr,
  output logic [DW-1:0] out_data
);
  localparam int PW = $clog2(DEPTH);
  localparam logic [PW:0] FULL_CNT = (PW+1)'(DEPTH);

  logic [AW-1:0] addr_mem [DEPTH];
  logic [DW-1:0] data_mem [DEPTH];
  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [PW:0]   cnt_q, cnt_d;
  logic          pop;

  assign full      = (cnt_q == FULL_CNT);
  assign empty     = (cnt_q == '0);
  assign out_valid = !empty;
  assign out_addr  = addr_mem[rp_q];
  assign out_data  = data_mem[rp_q];
  assign pop       = out_valid && out_ready;

  always_comb begin
    wp_d  = push ? wp_q + PW'(1) : wp_q;
    rp_d  = pop  ? rp_q + PW'(1) : rp_q;
    cnt_d = cnt_q + (PW+1)'(push) - (PW+1)'(pop);
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      addr_mem[wp_q] <= push_addr;
      data_mem[wp_q] <= push_data;
    end
  end

  // R9 R10: posted writes never exceed the buffer
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_s)
    push |-> !full);
endmodule

// File: rtl/dc_cache.sv
module dc_cache #(
  parameter int CAP_BYTES = 2048,
  parameter int AW        = 30,
  parameter int DW        = 32,
  parameter int WPL       = 4,
  parameter int WB_DEPTH  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic          req_wthru,
  input  logic          req_lock,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          resp_valid,
  output logic [DW-1:0] resp_rdata,
  output logic          mem_rd_req,
  output logic [AW-1:0] mem_rd_addr,
  input  logic          mem_rd_valid,
  input  logic [DW-1:0] mem_rd_data,
  output logic          mem_wr_valid,
  input  logic          mem_wr_ready,
  output logic [AW-1:0] mem_wr_addr,
  output logic [DW-1:0] mem_wr_data
);
  import dc_pkg::*;

  localparam int WAYS   = 2;
  localparam int WOFF_W = $clog2(WPL);
  localparam int SETS   = CAP_BYTES / (WPL * (DW / 8) * WAYS);
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = AW - IDX_W - WOFF_W;
  localparam logic [WOFF_W-1:0] LAST = WOFF_W'(WPL - 1);

  logic rst_s;
  dc_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_s(rst_s));

  // storage: tags and data without reset, status bits with reset
  logic [DW-1:0]    data_mem [SETS][WAYS][WPL];
  logic [TAG_W-1:0] tag_mem  [SETS][WAYS];
  logic [WAYS-1:0]  vld_q [SETS];
  logic [WAYS-1:0]  dty_q [SETS];
  logic [WAYS-1:0]  lck_q [SETS];
  logic [SETS-1:0]  lru_q;

  // latched request and registered array read
  logic             rq_write, rq_wt, rq_lock;
  logic [AW-1:0]    rq_addr;
  logic [DW-1:0]    rq_wdata;
  logic [TAG_W-1:0] rtag_q  [WAYS];
  logic [DW-1:0]    rword_q [WAYS];

  dc_state_e         st_q, st_d;
  logic [WOFF_W-1:0] cnt_q, cnt_d;
  logic              way_q, way_d, rd_pend_q, rd_pend_d;

  logic [TAG_W-1:0]  rq_tag;
  logic [IDX_W-1:0]  rq_idx, req_idx;
  logic [WOFF_W-1:0] rq_woff, req_woff, woff_k;
  logic [WAYS-1:0]   hit_vec;
  logic              hit, hit_way, vic_way, vic_none, accept;

  logic              wb_push, wb_full, wb_empty;
  logic [AW-1:0]     wb_paddr;
  logic [DW-1:0]     wb_pdata;
  logic              dwr_en, dwr_way;
  logic [WOFF_W-1:0] dwr_woff;
  logic [DW-1:0]     dwr_data;
  logic              hit_upd, set_dirty, fill_done;

  assign rq_tag   = rq_addr[AW-1 -: TAG_W];
  assign rq_idx   = rq_addr[WOFF_W +: IDX_W];
  assign rq_woff  = rq_addr[WOFF_W-1:0];
  assign req_idx  = req_addr[WOFF_W +: IDX_W];
  assign req_woff = req_addr[WOFF_W-1:0];
  assign woff_k   = rq_woff + cnt_q;
  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_valid && req_ready;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = vld_q[rq_idx][w] && (rtag_q[w] == rq_tag);
  end
  assign hit     = |hit_vec;
  assign hit_way = hit_vec[1];

  dc_victim u_vic (
    .vld (vld_q[rq_idx]),
    .lck (lck_q[rq_idx]),
    .lru (lru_q[rq_idx]),
    .way (vic_way),
    .none(vic_none)
  );

  dc_wbuf #(.DEPTH(WB_DEPTH), .AW(AW), .DW(DW)) u_wb (
    .clk      (clk),
    .rst_s    (rst_s),
    .push     (wb_push),
    .push_addr(wb_paddr),
    .push_data(wb_pdata),
    .full     (wb_full),
    .empty    (wb_empty),
    .out_valid(mem_wr_valid),
    .out_ready(mem_wr_ready),
    .out_addr (mem_wr_addr),
    .out_data (mem_wr_data)
  );

  // next-state logic
  always_comb begin
    st_d = st_q; cnt_d = cnt_q; way_d = way_q; rd_pend_d = rd_pend_q;
    resp_valid = 1'b0; resp_rdata = '0;
    wb_push = 1'b0; wb_paddr = rq_addr; wb_pdata = rq_wdata;
    dwr_en = 1'b0; dwr_way = hit_way; dwr_woff = rq_woff; dwr_data = rq_wdata;
    hit_upd = 1'b0; set_dirty = 1'b0; fill_done = 1'b0;
    mem_rd_req = 1'b0; mem_rd_addr = rq_addr;
    unique case (st_q)
      ST_IDLE: if (req_valid) st_d = ST_CMP;
      ST_CMP: begin
        if (hit && !rq_write) begin
          resp_valid = 1'b1; resp_rdata = rword_q[hit_way];
          hit_upd = 1'b1; st_d = ST_IDLE;
        end else if (hit && (!rq_wt || !wb_full)) begin
          dwr_en = 1'b1; hit_upd = 1'b1; set_dirty = !rq_wt; wb_push = rq_wt;
          resp_valid = 1'b1; st_d = ST_IDLE;
        end else if (!hit && rq_write && rq_wt) begin
          if (!wb_full) begin
            wb_push = 1'b1; resp_valid = 1'b1; st_d = ST_IDLE;
          end
        end else if (!hit && vic_none) begin
          st_d = ST_UNC;
        end else if (!hit) begin
          way_d = vic_way; cnt_d = '0;
          st_d = (vld_q[rq_idx][vic_way] && dty_q[rq_idx][vic_way]) ? ST_EVICT : ST_FILL;
        end
      end
      ST_EVICT: if (!wb_full) begin
        wb_push  = 1'b1;
        wb_paddr = {tag_mem[rq_idx][way_q], rq_idx, cnt_q};
        wb_pdata = data_mem[rq_idx][way_q][cnt_q];
        cnt_d    = cnt_q + WOFF_W'(1);
        if (cnt_q == LAST) st_d = ST_FILL;
      end
      ST_FILL: begin
        if (rd_pend_q) begin
          if (mem_rd_valid) begin
            dwr_en = 1'b1; dwr_way = way_q; dwr_woff = woff_k;
            dwr_data = (cnt_q == '0 && rq_write) ? rq_wdata : mem_rd_data;
            rd_pend_d = 1'b0;
            cnt_d = cnt_q + WOFF_W'(1);
            if (cnt_q == '0) begin
              resp_valid = 1'b1; resp_rdata = mem_rd_data;
            end
            if (cnt_q == LAST) begin
              fill_done = 1'b1; st_d = ST_IDLE;
            end
          end
        end else if (wb_empty) begin
          mem_rd_req = 1'b1; mem_rd_addr = {rq_tag, rq_idx, woff_k};
          rd_pend_d = 1'b1;
        end
      end
      ST_UNC: begin
        if (rq_write) begin
          if (!wb_full) begin
            wb_push = 1'b1; resp_valid = 1'b1; st_d = ST_IDLE;
          end
        end else if (rd_pend_q) begin
          if (mem_rd_valid) begin
            resp_valid = 1'b1; resp_rdata = mem_rd_data;
            rd_pend_d = 1'b0; st_d = ST_IDLE;
          end
        end else if (wb_empty) begin
          mem_rd_req = 1'b1; rd_pend_d = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      st_q <= ST_IDLE; cnt_q <= '0; way_q <= 1'b0; rd_pend_q <= 1'b0;
    end else begin
      st_q <= st_d; cnt_q <= cnt_d; way_q <= way_d; rd_pend_q <= rd_pend_d;
    end
  end

  // status registers
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      lru_q <= '0;
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0; dty_q[s] <= '0; lck_q[s] <= '0;
      end
    end else begin
      if (hit_upd) begin
        lru_q[rq_idx] <= !hit_way;
        if (rq_lock)   lck_q[rq_idx][hit_way] <= 1'b1;
        if (set_dirty) dty_q[rq_idx][hit_way] <= 1'b1;
      end
      if (fill_done) begin
        vld_q[rq_idx][way_q] <= 1'b1;
        dty_q[rq_idx][way_q] <= rq_write;
        lck_q[rq_idx][way_q] <= rq_lock;
        lru_q[rq_idx]        <= !way_q;
      end
    end
  end

  // datapath registers: request latch, array read, array write
  always_ff @(posedge clk) begin
    if (accept) begin
      rq_write <= req_write; rq_wt <= req_wthru; rq_lock <= req_lock;
      rq_addr  <= req_addr;  rq_wdata <= req_wdata;
      for (int w = 0; w < WAYS; w++) begin
        rtag_q[w]  <= tag_mem[req_idx][w];
        rword_q[w] <= data_mem[req_idx][w][req_woff];
      end
    end
    if (dwr_en)    data_mem[rq_idx][dwr_way][dwr_woff] <= dwr_data;
    if (fill_done) tag_mem[rq_idx][way_q] <= rq_tag;
  end

  // R2: a tag is never resident in both ways
  assert_single_hit_R2: assert property (@(posedge clk) disable iff (!rst_s)
    (st_q == ST_CMP) |-> $onehot0(hit_vec));
  // R5: the way being refilled was not locked
  assert_victim_unlocked_R5: assert property (@(posedge clk) disable iff (!rst_s)
    (st_q == ST_FILL) |-> !lck_q[rq_idx][way_q]);
  // R4: during a refill the core is answered only on the first beat
  assert_critical_first_R4: assert property (@(posedge clk) disable iff (!rst_s)
    (st_q == ST_FILL && resp_valid) |-> (cnt_q == '0));
  // R7: bypassed accesses leave the set's valid bits alone
  assert_bypass_no_alloc_R7: assert property (@(posedge clk) disable iff (!rst_s)
    (st_q == ST_UNC) |=> $stable(vld_q[rq_idx]));
endmodule

// File: tb/sim_dc_cache.sv
module sim_dc_cache;
  localparam int CLK_PERIOD = 10;
  localparam int RD_LAT     = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_write, req_wthru, req_lock;
  logic [29:0] req_addr;
  logic [31:0] req_wdata;
  logic        resp_valid;
  logic [31:0] resp_rdata;
  logic        mem_rd_req, mem_rd_valid;
  logic [29:0] mem_rd_addr;
  logic [31:0] mem_rd_data;
  logic        mem_wr_valid, mem_wr_ready;
  logic [29:0] mem_wr_addr;
  logic [31:0] mem_wr_data;

  dc_cache u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_wthru(req_wthru), .req_lock(req_lock), .req_addr(req_addr),
    .req_wdata(req_wdata), .resp_valid(resp_valid), .resp_rdata(resp_rdata),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
    .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [31:0] mem     [4096];
  logic [31:0] ref_mem [4096];
  int rd_log [4096];
  int nrd = 0, nwr = 0, rd_cd = 0, cyc = 0;
  logic [11:0] rd_a;
  int nchk = 0, nerr = 0;
  bit done = 0;

  // memory model: one outstanding single-word read, throttled writes
  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_rd_valid <= 1'b0;
    if (rd_cd > 0) begin
      rd_cd <= rd_cd - 1;
      if (rd_cd == 1) begin
        mem_rd_valid <= 1'b1;
        mem_rd_data  <= mem[rd_a];
      end
    end
    if (mem_rd_req) begin
      rd_cd <= RD_LAT;
      rd_a  <= mem_rd_addr[11:0];
      rd_log[nrd % 4096] = int'(mem_rd_addr);
      nrd = nrd + 1;
    end
    if (mem_wr_valid && mem_wr_ready) begin
      mem[mem_wr_addr[11:0]] <= mem_wr_data;
      nwr = nwr + 1;
    end
  end
  always @(negedge clk) mem_wr_ready <= (cyc % 3) != 0;

  function automatic logic [29:0] mk(input int t, input int s, input int w);
    return 30'(t * 256 + s * 4 + w);
  endfunction

  task automatic finish_up;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  endtask

  task automatic chk(input string rq, input logic ok, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  // one access: returns data, latency in cycles, reads at response, total reads, first log slot
  task automatic acc(input logic w, input logic wt, input logic lk, input logic [29:0] a,
                     input logic [31:0] d, output logic [31:0] rd, output int lat,
                     output int rresp, output int reads, output int r0);
    int c;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    r0 = nrd;
    req_valid = 1'b1; req_write = w; req_wthru = wt; req_lock = lk;
    req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    c = 1;
    while (!resp_valid && c < 1000) begin @(negedge clk); c++; end
    rd = resp_rdata; lat = c; rresp = nrd - r0;
    while (!req_ready) @(negedge clk);
    reads = nrd - r0;
    if (w) ref_mem[a[11:0]] = d;
  endtask

  task automatic drain;
    @(negedge clk);
    while (!(req_ready && !mem_wr_valid)) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_up();
  end

  initial begin
    logic [31:0] rd;
    int lat, rresp, reads, r0, w0;
    logic [29:0] a;
    req_valid = 0; req_write = 0; req_wthru = 0; req_lock = 0;
    req_addr = '0; req_wdata = '0; mem_rd_valid = 0; mem_rd_data = '0;
    mem_wr_ready = 0;
    for (int i = 0; i < 4096; i++) begin
      mem[i] = 32'(i) * 32'h0101_0101 ^ 32'hA5A5_0000;
      ref_mem[i] = mem[i];
    end
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 ready", req_ready == 1'b1, req_ready, 1);
    chk("R1 outputs idle", {resp_valid, mem_rd_req, mem_wr_valid} == 3'b000,
        {resp_valid, mem_rd_req, mem_wr_valid}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R3 R4: load miss, wrap order and early restart
    a = mk(1, 5, 2);
    acc(0, 0, 0, a, 0, rd, lat, rresp, reads, r0);
    chk("R1 R3 miss reads", reads == 4, reads, 4);
    chk("R3 load data", rd == ref_mem[a[11:0]], rd, ref_mem[a[11:0]]);
    chk("R4 resp after first word", rresp == 1, rresp, 1);
    for (int k = 0; k < 4; k++)
      chk("R3 wrap order", rd_log[(r0 + k) % 4096] == int'(mk(1, 5, (2 + k) % 4)),
          rd_log[(r0 + k) % 4096], mk(1, 5, (2 + k) % 4));

    // R2: hits
    acc(0, 0, 0, a, 0, rd, lat, rresp, reads, r0);
    chk("R2 hit latency", lat == 1, lat, 1);
    chk("R2 hit no read", reads == 0, reads, 0);
    chk("R2 hit data", rd == ref_mem[a[11:0]], rd, ref_mem[a[11:0]]);
    acc(0, 0, 0, mk(1, 5, 0), 0, rd, lat, rresp, reads, r0);
    chk("R2 hit other word", rd == ref_mem[mk(1, 5, 0)] && reads == 0, rd, ref_mem[mk(1, 5, 0)]);

    // R6: invalid way first, then LRU; R9 clean victim writes nothing
    acc(0, 0, 0, mk(2, 5, 0), 0, rd, lat, rresp, reads, r0);
    chk("R6 second line fills", reads == 4, reads, 4);
    acc(0, 0, 0, mk(1, 5, 1), 0, rd, lat, rresp, reads, r0);
    chk("R6 first line kept", reads == 0, reads, 0);
    drain(); w0 = nwr;
    acc(0, 0, 0, mk(3, 5, 0), 0, rd, lat, rresp, reads, r0);
    drain();
    chk("R9 clean victim no write", nwr == w0, nwr - w0, 0);
    acc(0, 0, 0, mk(1, 5, 3), 0, rd, lat, rresp, reads, r0);
    chk("R6 recently used kept", reads == 0, reads, 0);
    acc(0, 0, 0, mk(2, 5, 0), 0, rd, lat, rresp, reads, r0);
    chk("R6 LRU way evicted", reads == 4, reads, 4);

    // R5: lock on hit protects the line
    acc(0, 0, 1, mk(1, 5, 0), 0, rd, lat, rresp, reads, r0);
    acc(0, 0, 0, mk(4, 5, 0), 0, rd, lat, rresp, reads, r0);
    acc(0, 0, 0, mk(5, 5, 0), 0, rd, lat, rresp, reads, r0);
    acc(0, 0, 0, mk(6, 5, 0), 0, rd, lat, rresp, reads, r0);
    acc(0, 0, 0, mk(1, 5, 2), 0, rd, lat, rresp, reads, r0);
    chk("R5 locked line resident", reads == 0, reads, 0);

    // R7: lock on fill, then both locked -> bypass
    acc(0, 0, 1, mk(7, 5, 0), 0, rd, lat, rresp, reads, r0);
    chk("R5 lock on fill", reads == 4, reads, 4);
    a = mk(8, 5, 3);
    acc(0, 0, 0, a, 0, rd, lat, rresp, reads, r0);
    chk("R7 bypass one read", reads == 1, reads, 1);
    chk("R7 bypass data", rd == ref_mem[a[11:0]], rd, ref_mem[a[11:0]]);
    acc(0, 0, 0, a, 0, rd, lat, rresp, reads, r0);
    chk("R7 no allocation", reads == 1, reads, 1);
    acc(1, 0, 0, a, 32'hDEAD_0001, rd, lat, rresp, reads, r0);
    drain();
    chk("R7 bypass store to memory", mem[a[11:0]] == 32'hDEAD_0001, mem[a[11:0]], 32'hDEAD_0001);
    acc(0, 0, 0, a, 0, rd, lat, rresp, reads, r0);
    chk("R13 bypass load sees store", rd == 32'hDEAD_0001, rd, 32'hDEAD_0001);
    acc(0, 0, 0, mk(7, 5, 0), 0, rd, lat, rresp, reads, r0);
    chk("R5 locked fill resident", reads == 0, reads, 0);

    // R8 R9: write-back store hit, then dirty eviction
    a = mk(1, 9, 0);
    acc(0, 0, 0, a, 0, rd, lat, rresp, reads, r0);
    drain(); w0 = nwr;
    acc(1, 0, 0, a, 32'hCAFE_0009, rd, lat, rresp, reads, r0);
    drain();
    chk("R8 no memory write", nwr == w0, nwr - w0, 0);
    chk("R8 memory old", mem[a[11:0]] != 32'hCAFE_0009, mem[a[11:0]], 0);
    acc(0, 0, 0, a, 0, rd, lat, rresp, reads, r0);
    chk("R8 line updated", rd == 32'hCAFE_0009 && reads == 0, rd, 32'hCAFE_0009);
    acc(0, 0, 0, mk(2, 9, 0), 0, rd, lat, rresp, reads, r0);
    drain(); w0 = nwr;
    acc(0, 0, 0, mk(3, 9, 0), 0, rd, lat, rresp, reads, r0);
    drain();
    chk("R9 dirty line written back", nwr - w0 == 4, nwr - w0, 4);
    chk("R9 written data", mem[a[11:0]] == 32'hCAFE_0009, mem[a[11:0]], 32'hCAFE_0009);
    chk("R9 neighbour word", mem[mk(1, 9, 1)] == ref_mem[mk(1, 9, 1)], mem[mk(1, 9, 1)], ref_mem[mk(1, 9, 1)]);

    // R10: write-through store hit
    a = mk(1, 11, 1);
    acc(0, 0, 0, a, 0, rd, lat, rresp, reads, r0);
    drain(); w0 = nwr;
    acc(1, 1, 0, a, 32'hBEEF_0011, rd, lat, rresp, reads, r0);
    drain();
    chk("R10 one write", nwr - w0 == 1, nwr - w0, 1);
    chk("R10 memory updated", mem[a[11:0]] == 32'hBEEF_0011, mem[a[11:0]], 32'hBEEF_0011);
    acc(0, 0, 0, a, 0, rd, lat, rresp, reads, r0);
    chk("R10 line updated", rd == 32'hBEEF_0011 && reads == 0, rd, 32'hBEEF_0011);

    // R11: write-through store miss
    a = mk(1, 12, 2);
    w0 = nwr;
    acc(1, 1, 0, a, 32'h1234_0012, rd, lat, rresp, reads, r0);
    chk("R11 no fill", reads == 0, reads, 0);
    drain();
    chk("R11 one write", nwr - w0 == 1 && mem[a[11:0]] == 32'h1234_0012, mem[a[11:0]], 32'h1234_0012);
    acc(0, 0, 0, a, 0, rd, lat, rresp, reads, r0);
    chk("R11 not allocated", reads == 4, reads, 4);

    // R12: write-back store miss allocates
    a = mk(1, 13, 3);
    acc(1, 0, 0, a, 32'h5555_0013, rd, lat, rresp, reads, r0);
    chk("R12 allocates", reads == 4, reads, 4);
    chk("R4 R12 early ack", rresp == 1, rresp, 1);
    acc(0, 0, 0, a, 0, rd, lat, rresp, reads, r0);
    chk("R12 merged data", rd == 32'h5555_0013 && reads == 0, rd, 32'h5555_0013);
    drain();
    chk("R12 memory untouched", mem[a[11:0]] != 32'h5555_0013, mem[a[11:0]], 0);

    // R13: sweep all sets and several tags with mixed policies
    drain();
    do_reset();
    for (int i = 0; i < 4096; i++) ref_mem[i] = mem[i];
    for (int s = 0; s < 64; s++)
      for (int t = 1; t <= 4; t++) begin
        a = mk(t, s, (s + t) % 4);
        case ((s + t) % 3)
          0: begin
            acc(0, 0, 0, a, 0, rd, lat, rresp, reads, r0);
            chk("R13 sweep load", rd == ref_mem[a[11:0]], rd, ref_mem[a[11:0]]);
          end
          1: acc(1, 0, 0, a, 32'(s * 1000 + t), rd, lat, rresp, reads, r0);
          default: acc(1, 1, 0, a, 32'(s * 1000 + t + 77), rd, lat, rresp, reads, r0);
        endcase
      end
    for (int s = 0; s < 64; s++)
      for (int t = 1; t <= 4; t++) begin
        a = mk(t, s, (s + t) % 4);
        acc(0, 0, 0, a, 0, rd, lat, rresp, reads, r0);
        chk("R13 readback", rd == ref_mem[a[11:0]], rd, ref_mem[a[11:0]]);
      end
    finish_up();
  end
endmodule